// File: doc/BRIEF.md
# Paravirtual Device Common Configuration Registers

This block is the device-side register file for the common configuration area of a paravirtual PCI function. A driver reaches it through a simple register bus. The bus carries a word address, read and write strobes, byte enables and 32-bit data, and read data returns one cycle after the read strobe. The block presents the 64 offered feature bits through a selectable 32-bit window. It holds the 64 accepted feature bits, the configuration interrupt vector and the device status. It also holds a bank of per-queue registers, and a queue selector chooses which queue the bus sees.

The data path gets a one-cycle soft-reset pulse and the accepted feature bits. It also gets, for every queue at once, the size, the enable bit and the three 64-bit ring addresses. The driver resets the device by writing 0 to the status byte. Each queue size starts at the device maximum. The driver may lower a size to a smaller power of two, or write 0 to mark the queue unused.

Top module: `pvdev_common_regs`

## Requirements
- R1: The word map uses little-endian lanes. Word 4 bits [15:0] hold the config vector and bits [31:16] read the queue count (NQ), which writes do not change. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: Word 1 reads offered features [31:0] when the word-0 selector is 0 and reads [63:32] when it is 1. Any other selector value reads 0.
- R3: Word 3 writes and reads accepted features [31:0] when the word-2 selector is 0, and [63:32] when it is 1. With any other selector value, writes are ignored and reads return 0. `drv_features_o` carries the accepted bits.
- R4: Word 5 holds the status byte in bits [7:0] (written when `bus_be[0]` is set) and the queue selector in bits [31:16]. Writing status 0 raises `soft_reset_o` for exactly the next cycle.
- R5: Hard reset and the status-0 write both clear the accepted features, all queue enables and all ring addresses. They set every interrupt vector to 0xFFFF and restore every queue size to QMAX. The soft reset keeps the queue selector.
- R6: A queue size write (word 6 bits [15:0]) is kept only if it is 0, or a power of two no larger than QMAX. Any other value leaves the old size.
- R7: A write of 0 to 0x7FF to an interrupt vector (config vector: word 4 [15:0]; queue vector: word 6 [31:16]) is stored as written. Any larger value is stored as 0xFFFF.
- R8: With the queue selector at or above NQ, all per-queue words read 0 and per-queue writes change no queue.
- R9: Per-queue words apply to the selected queue. Word 7 bits [31:16] read the queue's notify offset, which equals its index.
- R10: Word 7 bit 0 is the queue enable (1 on, 0 off), driven on `q_enable_o`. Outputs do not change in a cycle with no write.
- R11: Ring addresses sit in words 8/9 (descriptor), 10/11 (available) and 12/13 (used), low half first. Each half is written only by a full 32-bit access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_feat_i | input | 64 | Offered feature bits |
| drv_features_o | output | 64 | Accepted feature bits |
| dev_status_o | output | 8 | Device status byte |
| soft_reset_o | output | 1 | One-cycle reset pulse to the data path |
| q_size_o | output | NQ*16 | Per-queue size |
| q_enable_o | output | NQ | Per-queue enable |
| q_desc_o | output | NQ*64 | Per-queue descriptor ring address |
| q_avail_o | output | NQ*64 | Per-queue available ring address |
| q_used_o | output | NQ*64 | Per-queue used ring address |

## Verification
The offered feature window is read under selector values 0, 1 and 2, and the accepted feature window is written under selectors 1 and 5. These tell the right half apart from a swapped half and from a write that should have been dropped. Queue size is written with a legal reduction, with a non-power-of-two, with a value above the maximum, with 0 and with the maximum itself. These tell the legality filter apart from a plain store. Vector writes at 0x7FF and 0x800, an out-of-range queue selector, and a status-0 write followed by a full output sweep show the clamp, the drop rule and the reset values.

// File: rtl/pvcfg_pkg.sv
package pvcfg_pkg;
  localparam int DW = 32;
  localparam int FIELD_W = 16;
  // word map
  localparam int W_DFSEL = 0;
  localparam int W_DFEAT = 1;
  localparam int W_GFSEL = 2;
  localparam int W_GFEAT = 3;
  localparam int W_CFGV = 4;
  localparam int W_STAT = 5;
  localparam int W_QSZV = 6;
  localparam int W_QENN = 7;
  localparam int W_RING0 = 8;
  localparam int W_RINGN = 13;
  localparam logic [15:0] NO_VEC = 16'hFFFF;
  localparam logic [15:0] VEC_LIM = 16'h07FF;

  function automatic logic [15:0] vec_clamp(input logic [15:0] v);
    return (v <= VEC_LIM) ? v : NO_VEC;
  endfunction

  function automatic logic size_ok(input logic [15:0] v, input int unsigned maxv);
    return (v == 16'd0) || ((32'(v) <= maxv) && ((v & (v - 16'd1)) == 16'd0));
  endfunction
endpackage

// File: rtl/pvcfg_feature_win.sv
module pvcfg_feature_win #(
  parameter int NWIN = 2
) (
  input  logic                 clk,
  input  logic                 clr_sel,
  input  logic                 clr_feat,
  input  logic                 wr_dsel,
  input  logic                 wr_gsel,
  input  logic                 wr_gfeat,
  input  logic [31:0]          wdata,
  input  logic [NWIN*32-1:0]   dev_feat_i,
  output logic [31:0]          dsel_o,
  output logic [31:0]          gsel_o,
  output logic [31:0]          dev_win_o,
  output logic [31:0]          drv_win_o,
  output logic [NWIN*32-1:0]   drv_feat_o
);
  logic [31:0] dsel_q, gsel_q;
  logic [31:0] acc_q [NWIN];

  always_ff @(posedge clk) begin
    if (clr_sel) begin
      dsel_q <= '0;
      gsel_q <= '0;
    end else begin
      if (wr_dsel) dsel_q <= wdata;
      if (wr_gsel) gsel_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < NWIN; w++) begin
      if (clr_feat) acc_q[w] <= '0;
      else if (wr_gfeat && gsel_q == 32'(w)) acc_q[w] <= wdata;
    end
  end

  always_comb begin
    dev_win_o = '0;
    drv_win_o = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (dsel_q == 32'(w)) dev_win_o = dev_feat_i[w*32 +: 32];
      if (gsel_q == 32'(w)) drv_win_o = acc_q[w];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_flat
      assign drv_feat_o[g*32 +: 32] = acc_q[g];
    end
  endgenerate

  assign dsel_o = dsel_q;
  assign gsel_o = gsel_q;
endmodule

// File: rtl/pvcfg_queue_bank.sv
module pvcfg_queue_bank
  import pvcfg_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QMAX = 256
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [15:0]       sel,
  input  logic              wr_size,
  input  logic              wr_vec,
  input  logic              wr_en,
  input  logic              wr_ring,
  input  logic [2:0]        ring_word,
  input  logic [31:0]       wdata,
  output logic [15:0]       rd_size,
  output logic [15:0]       rd_vec,
  output logic              rd_en,
  output logic [15:0]       rd_notify,
  output logic [31:0]       rd_ring,
  output logic [NQ*16-1:0]  q_size_o,
  output logic [NQ-1:0]     q_enable_o,
  output logic [NQ*64-1:0]  q_desc_o,
  output logic [NQ*64-1:0]  q_avail_o,
  output logic [NQ*64-1:0]  q_used_o
);
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int NRING = 3;

  logic [15:0] size_q [NQ];
  logic [15:0] vec_q  [NQ];
  logic        en_q   [NQ];
  logic [63:0] ring_q [NQ][NRING];

  logic          sel_ok;
  logic [IW-1:0] idx;
  logic [1:0]    ring_sel;

  assign sel_ok   = (sel < 16'(NQ));
  assign idx      = sel[IW-1:0];
  assign ring_sel = ring_word[2:1];

  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (clr) begin
        size_q[q] <= 16'(QMAX);
        vec_q[q]  <= NO_VEC;
        en_q[q]   <= 1'b0;
        for (int r = 0; r < NRING; r++) ring_q[q][r] <= '0;
      end else if (sel == 16'(q)) begin
        if (wr_size && size_ok(wdata[15:0], QMAX)) size_q[q] <= wdata[15:0];
        if (wr_vec) vec_q[q] <= vec_clamp(wdata[31:16]);
        if (wr_en)  en_q[q]  <= wdata[0];
        for (int r = 0; r < NRING; r++) begin
          if (wr_ring && ring_sel == 2'(r)) begin
            if (ring_word[0]) ring_q[q][r][63:32] <= wdata;
            else              ring_q[q][r][31:0]  <= wdata;
          end
        end
      end
    end
  end

  always_comb begin
    rd_size   = '0;
    rd_vec    = '0;
    rd_en     = 1'b0;
    rd_notify = '0;
    rd_ring   = '0;
    if (sel_ok) begin
      rd_size   = size_q[idx];
      rd_vec    = vec_q[idx];
      rd_en     = en_q[idx];
      rd_notify = sel;
      if (ring_sel < 2'(NRING))
        rd_ring = ring_word[0] ? ring_q[idx][ring_sel][63:32] : ring_q[idx][ring_sel][31:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_out
      assign q_size_o[g*16 +: 16] = size_q[g];
      assign q_enable_o[g]        = en_q[g];
      assign q_desc_o[g*64 +: 64]  = ring_q[g][0];
      assign q_avail_o[g*64 +: 64] = ring_q[g][1];
      assign q_used_o[g*64 +: 64]  = ring_q[g][2];
    end
  endgenerate
endmodule

// File: rtl/pvdev_common_regs.sv
module pvdev_common_regs
  import pvcfg_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QMAX = 256,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       dev_feat_i,
  output logic [63:0]       drv_features_o,
  output logic [7:0]        dev_status_o,
  output logic              soft_reset_o,
  output logic [NQ*16-1:0]  q_size_o,
  output logic [NQ-1:0]     q_enable_o,
  output logic [NQ*64-1:0]  q_desc_o,
  output logic [NQ*64-1:0]  q_avail_o,
  output logic [NQ*64-1:0]  q_used_o
);
  localparam logic [15:0] NQ16 = 16'(NQ);

  logic lo16, hi16, full32;
  logic at_dfsel, at_gfsel, at_gfeat, at_cfgv, at_stat, at_qszv, at_qenn, at_ring;
  logic status_zero, clr_all;
  logic [15:0] cfgv_q, qsel_q;
  logic [7:0]  status_q;
  logic [2:0]  ring_word;
  logic [31:0] dsel, gsel, dev_win, drv_win, rd_ring, rd_mux;
  logic [15:0] rd_size, rd_vec, rd_notify;
  logic        rd_en;

  assign lo16   = &bus_be[1:0];
  assign hi16   = &bus_be[3:2];
  assign full32 = &bus_be;

  assign at_dfsel = bus_wr && bus_addr == ADDR_W'(W_DFSEL);
  assign at_gfsel = bus_wr && bus_addr == ADDR_W'(W_GFSEL);
  assign at_gfeat = bus_wr && bus_addr == ADDR_W'(W_GFEAT);
  assign at_cfgv  = bus_wr && bus_addr == ADDR_W'(W_CFGV);
  assign at_stat  = bus_wr && bus_addr == ADDR_W'(W_STAT);
  assign at_qszv  = bus_wr && bus_addr == ADDR_W'(W_QSZV);
  assign at_qenn  = bus_wr && bus_addr == ADDR_W'(W_QENN);
  assign at_ring  = bus_wr && bus_addr >= ADDR_W'(W_RING0) && bus_addr <= ADDR_W'(W_RINGN);
  assign ring_word = 3'(bus_addr - ADDR_W'(W_RING0));

  assign status_zero = at_stat && bus_be[0] && bus_wdata[7:0] == 8'h00;
  assign clr_all     = rst || status_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= '0;
      qsel_q       <= '0;
      soft_reset_o <= 1'b0;
    end else begin
      soft_reset_o <= status_zero;
      if (at_stat && bus_be[0]) status_q <= bus_wdata[7:0];
      if (at_stat && hi16)      qsel_q   <= bus_wdata[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (clr_all)             cfgv_q <= NO_VEC;
    else if (at_cfgv && lo16) cfgv_q <= vec_clamp(bus_wdata[15:0]);
  end

  pvcfg_feature_win #(.NWIN(2)) u_feat (
    .clk(clk), .clr_sel(rst), .clr_feat(clr_all),
    .wr_dsel(at_dfsel && full32), .wr_gsel(at_gfsel && full32), .wr_gfeat(at_gfeat && full32),
    .wdata(bus_wdata), .dev_feat_i(dev_feat_i),
    .dsel_o(dsel), .gsel_o(gsel), .dev_win_o(dev_win), .drv_win_o(drv_win),
    .drv_feat_o(drv_features_o)
  );

  pvcfg_queue_bank #(.NQ(NQ), .QMAX(QMAX)) u_bank (
    .clk(clk), .clr(clr_all), .sel(qsel_q),
    .wr_size(at_qszv && lo16), .wr_vec(at_qszv && hi16), .wr_en(at_qenn && lo16),
    .wr_ring(at_ring && full32), .ring_word(ring_word), .wdata(bus_wdata),
    .rd_size(rd_size), .rd_vec(rd_vec), .rd_en(rd_en), .rd_notify(rd_notify), .rd_ring(rd_ring),
    .q_size_o(q_size_o), .q_enable_o(q_enable_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr >= ADDR_W'(W_RING0) && bus_addr <= ADDR_W'(W_RINGN)) rd_mux = rd_ring;
    else begin
      case (int'(bus_addr))
        W_DFSEL: rd_mux = dsel;
        W_DFEAT: rd_mux = dev_win;
        W_GFSEL: rd_mux = gsel;
        W_GFEAT: rd_mux = drv_win;
        W_CFGV:  rd_mux = {NQ16, cfgv_q};
        W_STAT:  rd_mux = {qsel_q, 8'h00, status_q};
        W_QSZV:  rd_mux = {rd_vec, rd_size};
        W_QENN:  rd_mux = {rd_notify, 15'h0, rd_en};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign dev_status_o = status_q;
endmodule

// File: rtl/pvcfg_sva.sv
module pvcfg_sva
  import pvcfg_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QMAX = 256,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              soft_reset_o,
  input logic [NQ-1:0]     q_enable_o,
  input logic [NQ*16-1:0]  q_size_o,
  input logic [63:0]       drv_features_o
);
  logic zero_wr;
  assign zero_wr = bus_wr && bus_addr == ADDR_W'(W_STAT) && bus_be[0] && bus_wdata[7:0] == 8'h00;

  // R4: status-0 write yields a pulse next cycle
  a_r4_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    zero_wr |=> soft_reset_o);
  // R4: pulse only after such a write
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |-> $past(zero_wr));
  // R5: pulse arrives with cleared enables and features
  a_r5_cleared: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |-> (q_enable_o == '0 && drv_features_o == '0));
  // R1: queue count readback
  a_r1_numq: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == ADDR_W'(W_CFGV)) |-> bus_rdata[31:16] == 16'(NQ));
  // R7: queue vector reads back in range or as no-vector
  a_r7_vec_range: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == ADDR_W'(W_QSZV)) |->
      (bus_rdata[31:16] <= VEC_LIM || bus_rdata[31:16] == NO_VEC));
  // R10: no write, no output change
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ($stable(q_enable_o) && $stable(q_size_o)));

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_sz
      // R6: every size stays legal
      a_r6_size_legal: assert property (@(posedge clk) disable iff (rst)
        size_ok(q_size_o[g*16 +: 16], QMAX));
    end
  endgenerate
endmodule

bind pvdev_common_regs pvcfg_sva #(.NQ(NQ), .QMAX(QMAX), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .soft_reset_o(soft_reset_o), .q_enable_o(q_enable_o), .q_size_o(q_size_o),
  .drv_features_o(drv_features_o)
);

// File: tb/tb_pvdev_common_regs.sv
module tb_pvdev_common_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int QMAX = 256;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 48;
  // reads check exp; req field is the requirement number (R1..R11)
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd4, 4'h0, 32'h0, 32'h0008FFFF, 4'd1},  // R1 count, R5 vector reset
    '{1'b1, 4'd0, 4'hF, 32'h1, 32'h0, 4'd2},
    '{1'b0, 4'd1, 4'h0, 32'h0, 32'hA5A50001, 4'd2},  // R2 upper half
    '{1'b1, 4'd0, 4'hF, 32'h0, 32'h0, 4'd2},
    '{1'b0, 4'd1, 4'h0, 32'h0, 32'h12345678, 4'd2},  // R2 lower half
    '{1'b1, 4'd0, 4'hF, 32'h2, 32'h0, 4'd2},
    '{1'b0, 4'd1, 4'h0, 32'h0, 32'h0, 4'd2},         // R2 out of range
    '{1'b1, 4'd2, 4'hF, 32'h1, 32'h0, 4'd3},
    '{1'b1, 4'd3, 4'hF, 32'hDEADBEEF, 32'h0, 4'd3},
    '{1'b0, 4'd3, 4'h0, 32'h0, 32'hDEADBEEF, 4'd3},  // R3 store
    '{1'b1, 4'd2, 4'hF, 32'h5, 32'h0, 4'd3},
    '{1'b1, 4'd3, 4'hF, 32'h11111111, 32'h0, 4'd3},
    '{1'b0, 4'd3, 4'h0, 32'h0, 32'h0, 4'd3},         // R3 reads 0
    '{1'b1, 4'd2, 4'hF, 32'h1, 32'h0, 4'd3},
    '{1'b0, 4'd3, 4'h0, 32'h0, 32'hDEADBEEF, 4'd3},  // R3 write ignored
    '{1'b1, 4'd5, 4'hC, 32'h00030000, 32'h0, 4'd9},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0100, 4'd9},  // R9 / R5 queue 3 reset view
    '{1'b1, 4'd6, 4'h3, 32'h40, 32'h0, 4'd6},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0040, 4'd6},  // R6 legal reduce
    '{1'b1, 4'd6, 4'h3, 32'h30, 32'h0, 4'd6},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0040, 4'd6},  // R6 not pow2
    '{1'b1, 4'd6, 4'h3, 32'h200, 32'h0, 4'd6},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0040, 4'd6},  // R6 above max
    '{1'b1, 4'd6, 4'h3, 32'h0, 32'h0, 4'd6},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0000, 4'd6},  // R6 zero
    '{1'b1, 4'd6, 4'hC, 32'h07FF0000, 32'h0, 4'd7},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'h07FF0000, 4'd7},  // R7 top entry
    '{1'b1, 4'd6, 4'hC, 32'h08000000, 32'h0, 4'd7},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0000, 4'd7},  // R7 clamp
    '{1'b0, 4'd7, 4'h0, 32'h0, 32'h00030000, 4'd9},  // R9 notify offset
    '{1'b1, 4'd7, 4'h3, 32'h1, 32'h0, 4'd10},
    '{1'b0, 4'd7, 4'h0, 32'h0, 32'h00030001, 4'd10}, // R10 enable
    '{1'b1, 4'd8, 4'hF, 32'h1000, 32'h0, 4'd11},
    '{1'b1, 4'd9, 4'hF, 32'h2, 32'h0, 4'd11},
    '{1'b0, 4'd8, 4'h0, 32'h0, 32'h1000, 4'd11},     // R11 low half
    '{1'b0, 4'd9, 4'h0, 32'h0, 32'h2, 4'd11},        // R11 high half
    '{1'b1, 4'd4, 4'h3, 32'h0123, 32'h0, 4'd7},
    '{1'b1, 4'd4, 4'hC, 32'hFFFF0000, 32'h0, 4'd1},
    '{1'b0, 4'd4, 4'h0, 32'h0, 32'h00080123, 4'd1},  // R1 count read-only
    '{1'b1, 4'd5, 4'h1, 32'h0F, 32'h0, 4'd4},
    '{1'b0, 4'd5, 4'h0, 32'h0, 32'h0003000F, 4'd4},  // R4 status + select
    '{1'b1, 4'd5, 4'hC, 32'h00090000, 32'h0, 4'd8},
    '{1'b1, 4'd6, 4'h3, 32'h10, 32'h0, 4'd8},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'h0, 4'd8},         // R8 reads 0
    '{1'b0, 4'd7, 4'h0, 32'h0, 32'h0, 4'd8},         // R8 reads 0
    '{1'b1, 4'd5, 4'hC, 32'h00000000, 32'h0, 4'd9},
    '{1'b1, 4'd6, 4'h3, 32'h100, 32'h0, 4'd6},
    '{1'b0, 4'd6, 4'h0, 32'h0, 32'hFFFF0100, 4'd6}   // R6 max accepted
  };

  logic clk = 1'b0;
  logic rst;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [3:0] bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] dev_feat_i, drv_features_o;
  logic [7:0] dev_status_o;
  logic soft_reset_o;
  logic [NQ*16-1:0] q_size_o;
  logic [NQ-1:0] q_enable_o;
  logic [NQ*64-1:0] q_desc_o, q_avail_o, q_used_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvdev_common_regs #(.NQ(NQ), .QMAX(QMAX), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_feat_i(dev_feat_i), .drv_features_o(drv_features_o), .dev_status_o(dev_status_o),
    .soft_reset_o(soft_reset_o), .q_size_o(q_size_o), .q_enable_o(q_enable_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic bread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [NQ*16-1:0] sizes_expected(input int zero_q);
    logic [NQ*16-1:0] s;
    for (int q = 0; q < NQ; q++) s[q*16 +: 16] = (q == zero_q) ? 16'd0 : 16'(QMAX);
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    dev_feat_i = 64'hA5A50001_12345678;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R5 hard reset state
    chk("R5 reset pulse low", 64'(soft_reset_o), 64'h0);
    chk("R5 reset sizes", 64'(q_size_o[63:0]), {4{16'(QMAX)}});
    chk("R5 reset enables", 64'(q_enable_o), 64'h0);
    chk("R1 reset rdata", 64'(bus_rdata), 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bwrite(VEC[i].addr, VEC[i].be, VEC[i].data);
      else begin
        bread(VEC[i].addr, rd);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(rd), 64'(VEC[i].exp));
      end
    end

    // select queue 3 again, outputs seen directly
    bwrite(4'd5, 4'hC, 32'h00030000);
    chk("R10 enable output", 64'(q_enable_o), 64'h08);
    chk("R11 desc output", q_desc_o[3*64 +: 64], 64'h00000002_00001000);
    chk("R11 avail untouched", q_avail_o[3*64 +: 64], 64'h0);
    chk("R8 sizes unchanged by dropped write", 64'(q_size_o == sizes_expected(3)), 64'h1);
    chk("R3 accepted features", drv_features_o, 64'hDEADBEEF_00000000);
    chk("R4 status output", 64'(dev_status_o), 64'h0F);

    // R11 partial-lane write ignored
    bwrite(4'd12, 4'h3, 32'h5555);
    chk("R11 partial write ignored", q_used_o[3*64 +: 64], 64'h0);

    // R4/R5 soft reset through status 0
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd5; bus_be = 4'h1; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
    chk("R4 pulse high", 64'(soft_reset_o), 64'h1);
    @(negedge clk);
    chk("R4 pulse one cycle", 64'(soft_reset_o), 64'h0);
    chk("R5 enables cleared", 64'(q_enable_o), 64'h0);
    chk("R5 features cleared", drv_features_o, 64'h0);
    chk("R5 sizes restored", 64'(q_size_o == sizes_expected(-1)), 64'h1);
    chk("R5 ring cleared", q_desc_o[3*64 +: 64], 64'h0);
    bread(4'd6, rd);
    chk("R5 queue view after soft reset", 64'(rd), 64'hFFFF0100);
    bread(4'd4, rd);
    chk("R5 config vector after soft reset", 64'(rd), 64'h0008FFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule